// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Host Register Port

This block is an asynchronous serial transmitter and receiver that a host drives through an 8-bit register port. The port has an active-low chip select, active-low read and write strobes and a control/data select. A transmitted byte goes first into a holding buffer and then into an output shifter. A received character goes from an input shifter into a holding buffer. This double buffering lets the host load the next byte while the current character is still on the line.

After reset the first control write sets the frame format: character length, parity and one or two stop bits. Every later control write is a command. A command enables the transmitter and the receiver, clears the error flags or sends the block back to waiting for a format byte. The transmitter starts only while the clear-to-send input is low and transmit is enabled. Bit timing uses a one-cycle enable pulse at 16 times the bit rate.

The receiver checks a start bit at mid-bit before it accepts the character. It records parity, overrun and framing errors in sticky status flags.

Top module: `usart_core`

## Requirements
- R1: After reset, the first write with cs_ni=0, wr_ni=0 and cd_i=1 loads the format byte. Later control writes are commands and never change the format. Format byte: bits [1:0] give the character length, 5 plus their value. Bit 2 enables parity. Bit 3 selects even parity (1) or odd parity (0). Bit 4 selects two stop bits.
- R2: A read with cd_i=1 returns status on data_o: bit0 transmit buffer empty, bit1 receive character ready, bit2 shifter empty, bit3 parity error, bit4 overrun error, bit5 framing error, bit6 awaiting format byte, bit7 zero. A read with cd_i=0 returns the receive buffer.
- R3: A data write fills the transmit buffer and drives txrdy_o low. The buffer moves into the shifter as soon as the shifter is free, and txrdy_o then returns high. A byte written while a frame is in flight is sent right after that frame.
- R4: A frame starts only while cts_ni is low and the transmit-enable command bit (bit 0) is set. Until then txempty_o stays high and txd_o stays high.
- R5: A frame on txd_o is a low start bit, the data bits LSB first, an optional parity bit and then high stop bits. Each bit lasts 16 baud ticks. txd_o is high whenever the shifter is empty.
- R6: All 24 combinations of length, parity and stop count from R1 produce the matching frame. With the receiver enabled (command bit 1), the receiver returns the same character.
- R7: A low level on the receive line is taken as a start bit only if it is still low 8 ticks after it was first seen. A shorter low pulse produces no character.
- R8: rxrdy_o rises when a full character is in the receive buffer, right-aligned with the upper bits zero. A data read clears it.
- R9: A parity bit that does not match the selected parity sets the parity error flag. The character is still delivered.
- R10: A character that completes while rxrdy_o is still high sets the overrun flag and replaces the buffered character.
- R11: A first stop bit sampled low sets the framing error flag.
- R12: Error flags stay set through later good characters until a command with bit 2 set clears them.
- R13: rst_ni low, or a command with bit 3 set, returns the block to awaiting a format byte. It empties both buffers, clears the flags and idles txd_o high, so the status reads 0x45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| cd_i | input | 1 | 1 selects control/status, 0 selects data |
| wr_ni | input | 1 | Write strobe, active low, one access per cycle held |
| rd_ni | input | 1 | Read strobe, active low |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data (status or receive buffer) |
| baud_tick_i | input | 1 | Enable pulse at 16x the bit rate |
| cts_ni | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| txrdy_o | output | 1 | Transmit buffer empty |
| txempty_o | output | 1 | Transmit shifter empty |
| rxrdy_o | output | 1 | Receive character ready |

## Verification
The bench sweeps all 24 frame formats in loopback. A wrong parity polarity, a wrong length or a missing second stop bit each give a captured frame or a returned character that differs from the arithmetic expectation. It holds clear-to-send high and transmit-enable low in turn. A design that ignores either gate starts a frame early and shows txempty_o falling. It sends a short low glitch, which a receiver without the mid-bit start check turns into a spurious character. It also sends frames with a bad parity bit, a low stop bit and two unread characters. Flags that are not sticky, or that cannot be cleared, show up in the status reads that follow.

// File: rtl/usart_pkg.sv
package usart_pkg;
  localparam int unsigned CHAR_MAX = 8;

  typedef struct packed {
    logic       stop2;
    logic       even;
    logic       par_en;
    logic [1:0] len_sel;
  } mode_t;

  localparam int unsigned CMD_TXEN = 0;
  localparam int unsigned CMD_RXEN = 1;
  localparam int unsigned CMD_ECLR = 2;
  localparam int unsigned CMD_IRST = 3;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  function automatic logic [3:0] char_len(input mode_t m);
    return 4'd5 + {2'b00, m.len_sel};
  endfunction
endpackage

// File: rtl/usart_regs.sv
module usart_regs
  import usart_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          cd_i,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_take_i,
  input  logic          rx_done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  output mode_t         mode_o,
  output logic          mode_pend_o,
  output logic          tx_en_o,
  output logic          rx_en_o,
  output logic          soft_rst_o,
  output logic          err_clr_o,
  output logic [DW-1:0] tx_buf_o,
  output logic          tx_full_o,
  output logic [DW-1:0] rx_buf_o,
  output logic          rxrdy_o,
  output logic          perr_o,
  output logic          oerr_o,
  output logic          ferr_o
);
  logic ctrl_wr, data_wr, data_rd;

  assign ctrl_wr    = !cs_ni && !wr_ni && cd_i;
  assign data_wr    = !cs_ni && !wr_ni && !cd_i;
  assign data_rd    = !cs_ni && !rd_ni && !cd_i;
  assign soft_rst_o = ctrl_wr && !mode_pend_o && wdata_i[CMD_IRST];
  assign err_clr_o  = ctrl_wr && !mode_pend_o && !wdata_i[CMD_IRST] && wdata_i[CMD_ECLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= '0;
      mode_pend_o <= 1'b1;
      tx_en_o     <= 1'b0;
      rx_en_o     <= 1'b0;
    end else if (ctrl_wr) begin
      if (mode_pend_o) begin
        mode_o      <= mode_t'(wdata_i[4:0]);
        mode_pend_o <= 1'b0;
      end else if (wdata_i[CMD_IRST]) begin
        mode_pend_o <= 1'b1;
        tx_en_o     <= 1'b0;
        rx_en_o     <= 1'b0;
      end else begin
        tx_en_o <= wdata_i[CMD_TXEN];
        rx_en_o <= wdata_i[CMD_RXEN];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_o  <= '0;
      tx_full_o <= 1'b0;
      rx_buf_o  <= '0;
      rxrdy_o   <= 1'b0;
      perr_o    <= 1'b0;
      oerr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else if (soft_rst_o) begin
      tx_full_o <= 1'b0;
      rxrdy_o   <= 1'b0;
      perr_o    <= 1'b0;
      oerr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      if (data_wr) begin
        tx_buf_o  <= wdata_i;
        tx_full_o <= 1'b1;
      end else if (tx_take_i) begin
        tx_full_o <= 1'b0;
      end
      if (err_clr_o) begin
        perr_o <= 1'b0;
        oerr_o <= 1'b0;
        ferr_o <= 1'b0;
      end
      if (rx_done_i) begin
        rx_buf_o <= rx_data_i;
        rxrdy_o  <= 1'b1;
        if (rxrdy_o && !data_rd) oerr_o <= 1'b1;
        if (rx_perr_i) perr_o <= 1'b1;
        if (rx_ferr_i) ferr_o <= 1'b1;
      end else if (data_rd) begin
        rxrdy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                tick_i,
  input  mode_t               mode_i,
  input  logic                en_i,
  input  logic                cts_ni,
  input  logic                full_i,
  input  logic [CHAR_MAX-1:0] data_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                txd_o
);
  localparam int unsigned CNT_W   = $clog2(OVS);
  localparam int unsigned FRAME_W = CHAR_MAX + 4;

  logic [CNT_W-1:0]   cnt_q;
  logic [3:0]         left_q;
  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] frame;
  logic [3:0]         len, nbits;
  logic               pbit;

  assign len    = char_len(mode_i);
  assign nbits  = 4'd2 + len + {3'b000, mode_i.par_en} + {3'b000, mode_i.stop2};
  assign take_o = !busy_o && full_i && en_i && !cts_ni;
  assign txd_o  = busy_o ? sh_q[0] : 1'b1;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    pbit     = ~mode_i.even;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < int'(len)) begin
        frame[i+1] = data_i[i];
        pbit       = pbit ^ data_i[i];
      end
    end
    if (mode_i.par_en) frame[len + 4'd1] = pbit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
      sh_q   <= '1;
    end else if (soft_rst_i) begin
      busy_o <= 1'b0;
      sh_q   <= '1;
    end else if (take_o) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
      left_q <= nbits;
      sh_q   <= frame;
    end else if (busy_o && tick_i) begin
      if (cnt_q == CNT_W'(OVS - 1)) begin
        cnt_q  <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy_o <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                tick_i,
  input  mode_t               mode_i,
  input  logic                en_i,
  input  logic                rxd_i,
  output logic                done_o,
  output logic [CHAR_MAX-1:0] data_o,
  output logic                perr_o,
  output logic                ferr_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned HALF  = OVS / 2;

  rx_st_e              st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [3:0]          bidx_q;
  logic [CHAR_MAX-1:0] sh_q, aligned;
  logic                pbit_q;
  logic [1:0]          sync_q;
  logic                rxs;
  logic [3:0]          len, nbits;

  assign rxs     = sync_q[1];
  assign len     = char_len(mode_i);
  assign nbits   = len + {3'b000, mode_i.par_en};
  assign aligned = sh_q >> (4'd8 - len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (soft_rst_i) begin
        st_q <= RX_IDLE;
      end else if (tick_i) begin
        unique case (st_q)
          RX_IDLE: if (en_i && !rxs) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              cnt_q  <= '0;
              bidx_q <= '0;
              st_q   <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          RX_DATA: begin
            if (cnt_q == CNT_W'(OVS - 1)) begin
              cnt_q <= '0;
              if (bidx_q < len) sh_q <= {rxs, sh_q[CHAR_MAX-1:1]};
              else              pbit_q <= rxs;
              if (bidx_q == nbits - 4'd1) st_q <= RX_STOP;
              bidx_q <= bidx_q + 4'd1;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          RX_STOP: begin
            if (cnt_q == CNT_W'(OVS - 1)) begin
              cnt_q  <= '0;
              st_q   <= RX_IDLE;
              done_o <= 1'b1;
              data_o <= aligned;
              perr_o <= mode_i.par_en && ((^aligned) ^ pbit_q ^ ~mode_i.even);
              ferr_o <= !rxs;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/usart_core.sv
module usart_core
  import usart_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          cd_i,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic          baud_tick_i,
  input  logic          cts_ni,
  output logic          txd_o,
  input  logic          rxd_i,
  output logic          txrdy_o,
  output logic          txempty_o,
  output logic          rxrdy_o
);
  mode_t         mode;
  logic          mode_pend, tx_en, rx_en, soft_rst, err_clr;
  logic [DW-1:0] tx_buf, rx_buf, rx_data;
  logic          tx_full, tx_take, tx_busy;
  logic          rx_done, rx_perr, rx_ferr;
  logic          par_err, ovr_err, frm_err;
  logic [DW-1:0] status;

  usart_regs #(.DW(DW)) regs_i (
    .clk_i, .rst_ni, .cs_ni, .cd_i, .wr_ni, .rd_ni,
    .wdata_i     (data_i),
    .tx_take_i   (tx_take),
    .rx_done_i   (rx_done),
    .rx_data_i   (rx_data),
    .rx_perr_i   (rx_perr),
    .rx_ferr_i   (rx_ferr),
    .mode_o      (mode),
    .mode_pend_o (mode_pend),
    .tx_en_o     (tx_en),
    .rx_en_o     (rx_en),
    .soft_rst_o  (soft_rst),
    .err_clr_o   (err_clr),
    .tx_buf_o    (tx_buf),
    .tx_full_o   (tx_full),
    .rx_buf_o    (rx_buf),
    .rxrdy_o     (rxrdy_o),
    .perr_o      (par_err),
    .oerr_o      (ovr_err),
    .ferr_o      (frm_err)
  );

  usart_tx #(.OVS(OVS)) tx_i (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst),
    .tick_i     (baud_tick_i),
    .mode_i     (mode),
    .en_i       (tx_en),
    .cts_ni,
    .full_i     (tx_full),
    .data_i     (tx_buf),
    .take_o     (tx_take),
    .busy_o     (tx_busy),
    .txd_o
  );

  usart_rx #(.OVS(OVS)) rx_i (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst),
    .tick_i     (baud_tick_i),
    .mode_i     (mode),
    .en_i       (rx_en),
    .rxd_i,
    .done_o     (rx_done),
    .data_o     (rx_data),
    .perr_o     (rx_perr),
    .ferr_o     (rx_ferr)
  );

  assign txrdy_o   = !tx_full;
  assign txempty_o = !tx_busy;
  assign status    = {1'b0, mode_pend, frm_err, ovr_err, par_err, txempty_o, rxrdy_o, txrdy_o};
  assign data_o    = cd_i ? status : rx_buf;
endmodule

// File: rtl/usart_core_chk.sv
module usart_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic cd_i,
  input logic wr_ni,
  input logic rd_ni,
  input logic cts_ni,
  input logic txd_o,
  input logic txrdy_o,
  input logic txempty_o,
  input logic rxrdy_o,
  input logic tx_en,
  input logic rx_done,
  input logic frm_err,
  input logic err_clr,
  input logic soft_rst
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txempty_o |-> txd_o); // R5

  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txempty_o) |-> !txd_o); // R5

  AST_TX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txempty_o) |-> ($past(!cts_ni) && $past(tx_en))); // R4

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && !cd_i) |=> !txrdy_o); // R3

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && !cd_i && !rx_done) |=> !rxrdy_o); // R8

  AST_FRAME_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_err && !err_clr && !soft_rst) |=> frm_err); // R12
endmodule

bind usart_core usart_core_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .cd_i      (cd_i),
  .wr_ni     (wr_ni),
  .rd_ni     (rd_ni),
  .cts_ni    (cts_ni),
  .txd_o     (txd_o),
  .txrdy_o   (txrdy_o),
  .txempty_o (txempty_o),
  .rxrdy_o   (rxrdy_o),
  .tx_en     (tx_en),
  .rx_done   (rx_done),
  .frm_err   (frm_err),
  .err_clr   (err_clr),
  .soft_rst  (soft_rst)
);

// File: tb/usart_core_tb_top.sv
module usart_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, cd_i = 1'b0, wr_ni = 1'b1, rd_ni = 1'b1;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       cts_ni = 1'b0;
  logic       txd_o, rxd, txrdy_o, txempty_o, rxrdy_o;
  logic       loop_en = 1'b0, rxd_drv = 1'b1;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;
  assign rxd = loop_en ? txd_o : rxd_drv;

  usart_core dut_i (
    .clk_i(clk), .rst_ni, .cs_ni, .cd_i, .wr_ni, .rd_ni, .data_i, .data_o,
    .baud_tick_i(1'b1), .cts_ni, .txd_o, .rxd_i(rxd), .txrdy_o, .txempty_o, .rxrdy_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic cd, input logic [7:0] v);
    @(negedge clk);
    cs_ni = 1'b0; wr_ni = 1'b0; cd_i = cd; data_i = v;
    @(negedge clk);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic rd(input logic cd, output logic [7:0] v);
    @(negedge clk);
    cs_ni = 1'b0; rd_ni = 1'b0; cd_i = cd;
    #1 v = data_o;
    @(negedge clk);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  function automatic int frame_bits(input int len, input bit pe, input bit s2);
    return 2 + len + int'(pe) + int'(s2);
  endfunction

  function automatic logic [11:0] frame_exp(input logic [7:0] v, input int len, input bit pe, input bit ev);
    logic [11:0] f;
    logic p;
    f = '1; f[0] = 1'b0; p = ~ev;
    for (int i = 0; i < len; i++) begin
      f[i+1] = v[i];
      p = p ^ v[i];
    end
    if (pe) f[len+1] = p;
    return f;
  endfunction

  task automatic capture(input int nb, output logic [11:0] got);
    int guard;
    got = '1; guard = 0;
    while (txd_o !== 1'b0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (7) @(negedge clk);
    got[0] = txd_o;
    for (int k = 1; k < nb; k++) begin
      repeat (16) @(negedge clk);
      got[k] = txd_o;
    end
  endtask

  task automatic wait_tx_idle();
    int guard;
    guard = 0;
    while (txempty_o !== 1'b1 && guard < 2000) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic send_rx(input logic [7:0] v, input int len, input bit pe, input bit ev,
                         input bit flip, input bit stop_lvl);
    logic p;
    p = ~ev ^ flip;
    rxd_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxd_drv = v[i];
      p = p ^ v[i];
      repeat (16) @(negedge clk);
    end
    if (pe) begin
      rxd_drv = p;
      repeat (16) @(negedge clk);
    end
    rxd_drv = stop_lvl;
    repeat (16) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  st, dv, v;
    logic [11:0] got;
    int          len;
    repeat (3) @(negedge clk);
    check("R13 reset txd", {31'd0, txd_o}, 32'd1);
    rst_ni = 1'b1;
    rd(1'b1, st);
    check("R13 reset status", {24'd0, st}, 32'h45);

    // R1: first control write is format, later ones are commands
    wr(1'b1, 8'h03);
    rd(1'b1, st);
    check("R1 format taken", {24'd0, st}, 32'h05);
    wr(1'b1, 8'h11);
    wr(1'b0, 8'hB7);
    capture(10, got);
    check("R1 frame keeps format", {20'd0, got}, {20'd0, frame_exp(8'hB7, 8, 1'b0, 1'b0)});
    wait_tx_idle();
    rd(1'b1, st);
    check("R1 R2 still command mode", {24'd0, st}, 32'h05);

    // R5 R6 R8: sweep all formats in loopback
    loop_en = 1'b1;
    for (int ls = 0; ls < 4; ls++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int s2 = 0; s2 < 2; s2++) begin
          bit pe, ev;
          pe  = (pm != 0);
          ev  = (pm == 1);
          len = 5 + ls;
          v   = 8'hA5 ^ 8'((ls * 12 + pm * 2 + s2) * 37);
          wr(1'b1, 8'h08);
          wr(1'b1, {3'b000, s2[0], ev, pe, ls[1:0]});
          wr(1'b1, 8'h03);
          wr(1'b0, v);
          capture(frame_bits(len, pe, s2[0]), got);
          check("R5 R6 tx frame", {20'd0, got}, {20'd0, frame_exp(v, len, pe, ev)});
          wait_tx_idle();
          repeat (6) @(negedge clk);
          rd(1'b1, st);
          check("R6 R8 rx status", {24'd0, st}, 32'h07);
          rd(1'b0, dv);
          check("R6 R8 rx data", {24'd0, dv}, {24'd0, v & 8'((1 << len) - 1)});
          rd(1'b1, st);
          check("R8 read clears", {24'd0, st}, 32'h05);
        end
      end
    end
    loop_en = 1'b0;

    // R4 gating and R3 double buffering
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h03);
    wr(1'b1, 8'h01);
    cts_ni = 1'b1;
    wr(1'b0, 8'h5A);
    repeat (40) @(negedge clk);
    check("R4 cts high holds", {29'd0, txempty_o, txd_o, txrdy_o}, 32'h6);
    cts_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 cts low starts", {31'd0, txempty_o}, 32'd0);
    check("R3 buffer moved", {31'd0, txrdy_o}, 32'd1);
    wr(1'b0, 8'hC3);
    check("R3 second byte held", {30'd0, txrdy_o, txempty_o}, 32'd0);
    begin
      int guard;
      guard = 0;
      while (txrdy_o !== 1'b1 && guard < 2000) begin
        @(negedge clk); guard++;
      end
    end
    capture(10, got);
    check("R3 second frame", {20'd0, got}, {20'd0, frame_exp(8'hC3, 8, 1'b0, 1'b0)});
    wait_tx_idle();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h77);
    repeat (40) @(negedge clk);
    check("R4 disabled holds", {30'd0, txempty_o, txd_o}, 32'h3);
    wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    check("R4 enable starts", {31'd0, txempty_o}, 32'd0);
    wait_tx_idle();

    // receiver error handling: 8 bits, even parity, 1 stop
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h0F);
    wr(1'b1, 8'h02);
    rxd_drv = 1'b0;
    repeat (5) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (40) @(negedge clk);
    rd(1'b1, st);
    check("R7 glitch rejected", {24'd0, st}, 32'h05);
    send_rx(8'h3C, 8, 1'b1, 1'b1, 1'b0, 1'b1);
    rd(1'b1, st);
    check("R7 R8 good char status", {24'd0, st}, 32'h07);
    rd(1'b0, dv);
    check("R8 good char data", {24'd0, dv}, 32'h3C);

    send_rx(8'h55, 8, 1'b1, 1'b1, 1'b1, 1'b1);
    rd(1'b1, st);
    check("R9 parity error", {24'd0, st}, 32'h0F);
    rd(1'b0, dv);
    check("R9 data kept", {24'd0, dv}, 32'h55);
    send_rx(8'h11, 8, 1'b1, 1'b1, 1'b0, 1'b1);
    rd(1'b1, st);
    check("R12 flag sticky", {24'd0, st}, 32'h0F);
    rd(1'b0, dv);
    wr(1'b1, 8'h06);
    rd(1'b1, st);
    check("R12 error reset", {24'd0, st}, 32'h05);

    send_rx(8'h81, 8, 1'b1, 1'b1, 1'b0, 1'b0);
    rd(1'b1, st);
    check("R11 framing error", {24'd0, st}, 32'h27);
    rd(1'b0, dv);
    wr(1'b1, 8'h06);

    send_rx(8'h12, 8, 1'b1, 1'b1, 1'b0, 1'b1);
    send_rx(8'h34, 8, 1'b1, 1'b1, 1'b0, 1'b1);
    rd(1'b1, st);
    check("R10 overrun flag", {24'd0, st}, 32'h17);
    rd(1'b0, dv);
    check("R10 newest kept", {24'd0, dv}, 32'h34);

    // R13 internal reset, then async reset mid-frame
    wr(1'b1, 8'h08);
    rd(1'b1, st);
    check("R13 command reset", {24'd0, st}, 32'h45);
    wr(1'b1, 8'h03);
    rd(1'b1, st);
    check("R13 format again", {24'd0, st}, 32'h05);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h00);
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R13 async reset outputs", {28'd0, txd_o, txempty_o, txrdy_o, rxrdy_o}, 32'hE);
    rst_ni = 1'b1;
    rd(1'b1, st);
    check("R13 async reset status", {24'd0, st}, 32'h45);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule